// File: doc/BRIEF.md
# Flag-Setting ALU with Shifter

This block is the data path of a small 8-bit controller core. Each cycle it takes a 6-bit operation code, a 4-bit shift selector and two data operands. Operand A is the destination register value. Operand B is either an immediate constant or a second register value, and that choice is made before the block. It produces the result word and a write enable for the destination register in the same cycle. It also keeps the carry and zero flags in two registers, which the next operation can use.

The supported operations are AND, OR and XOR, a flag-only bitwise test, a flag-only compare, addition and subtraction with or without the carry flag, and ten shift and rotate forms. The shift forms differ in how the vacated bit is filled. The flags change only when an operation the block knows is executed. If `exec_i` is low, or the operation code belongs to some other unit, the write enable stays low and both flags keep their values. Bit 0 of every two-code operation pair only chooses where operand B comes from, so the block ignores that bit.

Top module: `flag_alu`

## Requirements
- R1: Codes 00101x, 00110x and 00111x give A AND B, A OR B and A XOR B. Each writes the result, clears carry, and sets zero when the result is 0.
- R2: Code 01001x (test) does not write. It sets zero when A AND B is 0, and sets carry to the odd parity of A AND B.
- R3: Code 01010x (compare) does not write. It sets carry when A < B (unsigned) and sets zero when A equals B.
- R4: Code 01100x writes A+B mod 256. Code 01101x writes A+B+carry mod 256. Carry takes the carry out of bit 7.
- R5: Code 01110x writes A-B mod 256. Code 01111x writes A-B-carry mod 256. Carry is set on a borrow, that is, when the subtrahend (including the carry) exceeds A.
- R6: For 01101x and 01111x, zero is set only if the result is 0 and zero was already set. For all other codes, zero depends on the result alone.
- R7: Code 100000 with selector 0000, 0010, 0100, 0110 or 0111 shifts A left by one. The new bit 0 is the old carry, old bit 7, old bit 0, 0 or 1 respectively. Carry takes the old bit 7.
- R8: Code 100000 with selector 1000, 1010, 1100, 1110 or 1111 shifts A right by one. The new bit 7 is the old carry, old bit 7, old bit 0, 0 or 1 respectively. Carry takes the old bit 0.
- R9: While `exec_i` is low, `wr_en_o` is 0 and both flags hold their values.
- R10: Any other code, and code 100000 with any other selector, gives `wr_en_o` = 0 and leaves both flags unchanged.
- R11: An active-low `rst_ni` clears both flags asynchronously.
- R12: Flags update on the rising clock edge that ends an executed operation. `result_o` and `wr_en_o` follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute the presented operation this cycle |
| opcode_i | input | 6 | Operation code |
| shift_sel_i | input | 4 | Shift and rotate selector |
| op_a_i | input | 8 | Operand A, destination register value |
| op_b_i | input | 8 | Operand B, constant or second register |
| result_o | output | 8 | Result word |
| wr_en_o | output | 1 | Destination register write enable |
| carry_o | output | 1 | Registered carry flag |
| zero_o | output | 1 | Registered zero flag |

## Verification
The bench runs all 64 operation codes. For each code it uses both selectors and every third value of A, and pairs A with B equal to 0, 1, 0x80, 0xFF, A itself and the complement of A. Equal operands separate compare and chained zero from the non-chained cases. The values 0xFF and 0x80 expose carry out, borrow and parity. Because operations run back to back, the carry and zero flags that enter each carry-using operation vary naturally. The code 100000 is swept over all 16 selectors, so each of the ten fill rules and the six unused selectors is checked. Cycles with `exec_i` low, and a reset in the middle of the run, show that the flags hold and clear at the ports.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int OPC_W = 6;
  localparam int SEL_W = 4;

  typedef enum logic [3:0] {
    K_NONE, K_AND, K_OR, K_XOR, K_TEST, K_CMP,
    K_ADD, K_ADDC, K_SUB, K_SUBC, K_SHL, K_SHR
  } alu_kind_e;
endpackage

// File: rtl/flag_alu_decode.sv
module flag_alu_decode
  import flag_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [SEL_W-1:0] sel_i,
  output alu_kind_e        kind_o,
  output logic             writes_o
);
  alu_kind_e shift_kind;

  always_comb begin
    unique case (sel_i)
      4'b0000, 4'b0010, 4'b0100, 4'b0110, 4'b0111: shift_kind = K_SHL;
      4'b1000, 4'b1010, 4'b1100, 4'b1110, 4'b1111: shift_kind = K_SHR;
      default:                                     shift_kind = K_NONE;
    endcase
  end

  // bit 0 only picks the B source upstream
  always_comb begin
    case (opcode_i[OPC_W-1:1])
      5'b00101: kind_o = K_AND;
      5'b00110: kind_o = K_OR;
      5'b00111: kind_o = K_XOR;
      5'b01001: kind_o = K_TEST;
      5'b01010: kind_o = K_CMP;
      5'b01100: kind_o = K_ADD;
      5'b01101: kind_o = K_ADDC;
      5'b01110: kind_o = K_SUB;
      5'b01111: kind_o = K_SUBC;
      5'b10000: kind_o = opcode_i[0] ? K_NONE : shift_kind;
      default:  kind_o = K_NONE;
    endcase
  end

  assign writes_o = !(kind_o inside {K_NONE, K_TEST, K_CMP});
endmodule

// File: rtl/flag_alu_arith.sv
module flag_alu_arith
  import flag_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_kind_e     kind_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          c_i,
  input  logic          z_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          z_o
);
  logic          use_c;
  logic          chain;
  logic [DW:0]   sum;
  logic [DW:0]   dif;
  logic [DW-1:0] conj;

  assign use_c = (kind_i == K_ADDC) || (kind_i == K_SUBC);
  assign chain = use_c;
  assign sum   = {1'b0, a_i} + {1'b0, b_i} + (DW+1)'(use_c & c_i);
  assign dif   = {1'b0, a_i} - {1'b0, b_i} - (DW+1)'(use_c & c_i);
  assign conj  = a_i & b_i;

  always_comb begin
    res_o = '0;
    c_o   = 1'b0;
    unique case (kind_i)
      K_AND:          res_o = conj;
      K_OR:           res_o = a_i | b_i;
      K_XOR:          res_o = a_i ^ b_i;
      K_TEST: begin
        res_o = conj;
        c_o   = ^conj;
      end
      K_ADD, K_ADDC: begin
        res_o = sum[DW-1:0];
        c_o   = sum[DW];
      end
      K_CMP, K_SUB, K_SUBC: begin
        res_o = dif[DW-1:0];
        c_o   = dif[DW];
      end
      default: ;
    endcase
  end

  assign z_o = (res_o == '0) && (!chain || z_i);
endmodule

// File: rtl/flag_alu_shift.sv
module flag_alu_shift
  import flag_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             right_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DW-1:0]    a_i,
  input  logic             c_i,
  output logic [DW-1:0]    res_o,
  output logic             c_o
);
  logic fill;

  // same fill code for both directions on sel[2:0]
  always_comb begin
    case (sel_i[2:0])
      3'b000:  fill = c_i;
      3'b010:  fill = a_i[DW-1];
      3'b100:  fill = a_i[0];
      3'b111:  fill = 1'b1;
      default: fill = 1'b0;
    endcase
  end

  always_comb begin
    if (right_i) begin
      res_o = {fill, a_i[DW-1:1]};
      c_o   = a_i[0];
    end else begin
      res_o = {a_i[DW-2:0], fill};
      c_o   = a_i[DW-1];
    end
  end
endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic c_i,
  input  logic z_i,
  output logic c_o,
  output logic z_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_o <= 1'b0;
      z_o <= 1'b0;
    end else if (upd_i) begin
      c_o <= c_i;
      z_o <= z_i;
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             exec_i,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [SEL_W-1:0] shift_sel_i,
  input  logic [DW-1:0]    op_a_i,
  input  logic [DW-1:0]    op_b_i,
  output logic [DW-1:0]    result_o,
  output logic             wr_en_o,
  output logic             carry_o,
  output logic             zero_o
);
  alu_kind_e     kind;
  logic          writes;
  logic          is_shift;
  logic [DW-1:0] ar_res, sh_res;
  logic          ar_c, ar_z, sh_c;
  logic          c_nxt, z_nxt;

  flag_alu_decode i_decode (
    .opcode_i (opcode_i),
    .sel_i    (shift_sel_i),
    .kind_o   (kind),
    .writes_o (writes)
  );

  flag_alu_arith #(.DW(DW)) i_arith (
    .kind_i (kind),
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .c_i    (carry_o),
    .z_i    (zero_o),
    .res_o  (ar_res),
    .c_o    (ar_c),
    .z_o    (ar_z)
  );

  flag_alu_shift #(.DW(DW)) i_shift (
    .right_i (kind == K_SHR),
    .sel_i   (shift_sel_i),
    .a_i     (op_a_i),
    .c_i     (carry_o),
    .res_o   (sh_res),
    .c_o     (sh_c)
  );

  assign is_shift = (kind == K_SHL) || (kind == K_SHR);
  assign result_o = is_shift ? sh_res : ar_res;
  assign c_nxt    = is_shift ? sh_c : ar_c;
  assign z_nxt    = is_shift ? (sh_res == '0) : ar_z;
  assign wr_en_o  = exec_i && writes;

  flag_alu_flags i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .upd_i  (exec_i && (kind != K_NONE)),
    .c_i    (c_nxt),
    .z_i    (z_nxt),
    .c_o    (carry_o),
    .z_o    (zero_o)
  );
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       exec_i,
  input logic [5:0] opcode_i,
  input logic [3:0] shift_sel_i,
  input logic [7:0] op_a_i,
  input logic [7:0] op_b_i,
  input logic [7:0] result_o,
  input logic       wr_en_o,
  input logic       carry_o,
  input logic       zero_o
);
  a_r9_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |-> !wr_en_o);

  a_r9_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> ($stable(carry_o) && $stable(zero_o)));

  a_r2_test_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i[5:1] == 5'b01001) |-> !wr_en_o);

  a_r3_cmp_borrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && opcode_i[5:1] == 5'b01010) |=> (carry_o == $past(op_a_i < op_b_i)));

  a_r1_logic_clears_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && opcode_i[5:3] == 3'b001 && opcode_i[2:1] != 2'b00) |=> !carry_o);

  a_r6_chain_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && opcode_i[5:2] == 4'b0110 && opcode_i[1] && !zero_o) |=> !zero_o);

  a_r10_bad_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode_i == 6'b100000 && (shift_sel_i[0] && !shift_sel_i[1])) |-> !wr_en_o);
endmodule

bind flag_alu flag_alu_chk i_chk (.*);

// File: tb/test_flag_alu.sv
`timescale 1ns/1ps
module test_flag_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec = 1'b0;
  logic [5:0] opc = '0;
  logic [3:0] sel = '0;
  logic [7:0] a = '0, b = '0;
  logic [7:0] res;
  logic       wr, c_f, z_f;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic  m_c = 0, m_z = 0;
  string prev_tag = "R11";

  always #2.5 clk = ~clk;

  flag_alu i_flag_alu (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .opcode_i(opc),
    .shift_sel_i(sel), .op_a_i(a), .op_b_i(b), .result_o(res),
    .wr_en_o(wr), .carry_o(c_f), .zero_o(z_f)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h op=%b sel=%b a=%0h b=%0h",
               tag, act, exp, opc, sel, a, b);
    end
  endtask

  // expected behaviour per requirement
  task automatic model(input logic [5:0] o, input logic [3:0] s, input int x, input int y,
                       output bit known, output bit wre, output int r,
                       output logic nc, output logic nz, output string tag);
    int t;
    known = 1; wre = 1; r = 0; nc = 0; tag = "R10";
    case (o[5:1])
      5'b00101: begin r = x & y; tag = "R1"; end
      5'b00110: begin r = x | y; tag = "R1"; end
      5'b00111: begin r = x ^ y; tag = "R1"; end
      5'b01001: begin r = x & y; wre = 0; nc = ^r[7:0]; tag = "R2"; end
      5'b01010: begin r = (x - y) & 255; wre = 0; nc = x < y; tag = "R3"; end
      5'b01100: begin t = x + y; r = t % 256; nc = t > 255; tag = "R4"; end
      5'b01101: begin t = x + y + m_c; r = t % 256; nc = t > 255; tag = "R4"; end
      5'b01110: begin r = (x - y + 256) % 256; nc = y > x; tag = "R5"; end
      5'b01111: begin t = y + m_c; r = (x - t + 512) % 256; nc = t > x; tag = "R5"; end
      5'b10000: begin
        if (o[0]) known = 0;
        else begin
          int fill;
          case (s[2:0])
            3'd0: fill = m_c;
            3'd2: fill = x / 128;
            3'd4: fill = x % 2;
            3'd6: fill = 0;
            3'd7: fill = 1;
            default: known = 0;
          endcase
          if (s == 4'b0110 || s == 4'b1110 || s == 4'b0111 || s == 4'b1111 ||
              s[1:0] == 2'b00 || s[1:0] == 2'b10) begin end
          if (s[0] && s[2:1] != 2'b11) known = 0;
          if (known) begin
            if (!s[3]) begin r = ((x * 2) % 256) + fill; nc = x / 128; tag = "R7"; end
            else       begin r = (x / 2) + fill * 128;   nc = x % 2;   tag = "R8"; end
          end
        end
      end
      default: known = 0;
    endcase
    if (!known) begin wre = 0; nc = m_c; nz = m_z; end
    else if (o[5:1] == 5'b01101 || o[5:1] == 5'b01111) nz = (r == 0) && m_z;
    else nz = (r == 0);
  endtask

  task automatic step(input logic [5:0] o, input logic [3:0] s, input int x, input int y,
                      input logic e);
    bit known, wre; int r; logic nc, nz; string tag;
    @(negedge clk);
    chk({prev_tag, " R12 carry"}, c_f, m_c);
    chk({prev_tag, " R12 zero"}, z_f, m_z);
    opc = o; sel = s; a = x[7:0]; b = y[7:0]; exec = e;
    #1;
    model(o, s, x, y, known, wre, r, nc, nz, tag);
    if (!e) begin
      chk("R9 wr", wr, 0);
      prev_tag = "R9";
    end else begin
      chk({tag, " wr"}, wr, wre);
      if (wre) chk({tag, " result"}, res, r);
      if (o[5:1] == 5'b01101 || o[5:1] == 5'b01111) prev_tag = {tag, " R6"};
      else prev_tag = tag;
      m_c = nc; m_z = nz;
    end
  endtask

  initial begin
    int bl[6];
    #1;
    chk("R11 carry in reset", c_f, 0);
    chk("R11 zero in reset", z_f, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int o = 0; o < 64; o++) begin
      for (int si = 0; si < ((o == 32) ? 16 : 2); si++) begin
        logic [3:0] s = (o == 32) ? 4'(si) : (si == 0 ? 4'd0 : 4'd5);
        for (int x = 0; x < 256; x += 3) begin
          bl = '{0, 1, 128, 255, x, 255 - x};
          foreach (bl[k]) step(6'(o), s, x, bl[k], 1'b1);
        end
      end
    end
    // R9: flags hold with exec low for all kinds of op
    step(6'b011100, 0, 0, 1, 1'b1);  // sets carry
    for (int o = 0; o < 64; o++) step(6'(o), 4'd0, 0, 0, 1'b0);
    step(6'b011000, 0, 0, 0, 1'b1);  // zero set, carry clear
    for (int o = 0; o < 64; o++) step(6'(o), 4'd8, 255, 1, 1'b0);
    // R10: undefined selectors and foreign codes leave flags
    step(6'b011100, 0, 5, 6, 1'b1);
    step(6'b100000, 4'd1, 128, 0, 1'b1);
    step(6'b100001, 4'd0, 128, 0, 1'b1);
    step(6'b110100, 4'd0, 0, 0, 1'b1);
    @(negedge clk);
    chk("R10 carry kept", c_f, m_c);
    chk("R10 zero kept", z_f, m_z);
    // R11: reset mid-run clears flags
    step(6'b011100, 0, 0, 0, 1'b1);
    step(6'b011110, 0, 0, 0, 1'b1);
    @(negedge clk);
    exec = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R11 carry cleared", c_f, 0);
    chk("R11 zero cleared", z_f, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule